// File: doc/BRIEF.md
# Shaped-Pulse Self-Trigger with Time-Over-Threshold Qualification

This block watches the sample stream of one detector channel and produces a one-cycle trigger pulse when a pulse arrives. Each accepted sample feeds a fast shaping filter. The filter takes the difference between the new sample and the sample a programmable number of positions earlier. It then sums those differences over a programmable window, which gives a short, flat-topped response to a step. The running sum is updated incrementally: each new difference is added and the difference that leaves the window is subtracted.

The shaped value is compared with a signed threshold. A trigger is raised only when the shaped value has stayed above the threshold for a programmable number of consecutive accepted samples, so a single noisy sample cannot fire it. After firing, the trigger stays quiet until the shaped value falls back to or below the threshold. Configuration is expected to be held constant between resets. Samples are accepted only in cycles where the valid input is high.

Top module: `fir_tot_trigger`

## Requirements
- R1: While reset is asserted, and once it is released, `shaped_o` is 0 and `trig_o` is 0 until an accepted sample changes them; reset clears all sample and difference history to zero.
- R2: After the clock edge that accepts sample x[n] (in_valid high), `shaped_o` equals the sum over j = 0..L-1 of (x[n-j] - x[n-j-D]), where D is `cfg_diff_len`, L is `cfg_int_len`, and any sample before the last reset counts as 0.
- R3: On an edge where in_valid is low, `shaped_o` keeps its value, the filter history and run count do not advance, and `trig_o` is 0 in the following cycle.
- R4: With a difference length of 0, the shaped value stays 0 for every input.
- R5: With an integration length of 0, the shaped value stays 0 for every input.
- R6: A sample counts as above threshold only when its shaped value is strictly greater than `cfg_threshold`, both compared as two's-complement signed numbers.
- R7: `trig_o` is high for exactly one cycle, right after the edge that accepts the sample whose consecutive above-threshold run reaches the programmed count C.
- R8: C = 0 and C = 1 both fire on the first above-threshold sample of a run.
- R9: Within one above-threshold run the trigger fires at most once; it re-arms only after an accepted sample that is not above threshold.
- R10: A run of fewer than C above-threshold samples, ended by a sample at or below threshold, produces no trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample accept enable |
| in_sample | input | SAMPLE_W | Signed input sample |
| cfg_diff_len | input | LEN_W | Difference distance D in samples |
| cfg_int_len | input | LEN_W | Integration window L in samples |
| cfg_tot_count | input | CNT_W | Required consecutive above-threshold samples C |
| cfg_threshold | input | SAMPLE_W+1+LEN_W | Signed comparison threshold |
| shaped_o | output | SAMPLE_W+1+LEN_W | Signed shaped value |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench sweeps the difference and integration lengths across zero, one, small values and the maximum of 63, and the qualification count across 0, 1, 3 and 15. The stimulus mixes long steps, two-sample spikes, negative baselines and gaps in the valid input. A design with an off-by-one delay tap, or a window that subtracts the wrong old difference, drifts away from the directly summed expected value. Mishandling zero lengths leaves a non-zero residue. A design that counts runs wrongly fires early on spikes, fires twice on one long pulse, or never re-arms. Thresholds of zero against an all-zero shaped value separate a strict comparison from a non-strict one.

// File: rtl/fir_tot_pkg.sv
package fir_tot_pkg;

  // Bits needed for a running sum of up to (2**len_w - 1) differences
  // of two sample_w-bit signed values.
  function automatic int ftt_sum_width(input int sample_w, input int len_w);
    return sample_w + 1 + len_w;
  endfunction

  // Bits of one sample difference.
  function automatic int ftt_diff_width(input int sample_w);
    return sample_w + 1;
  endfunction

endpackage

// File: rtl/ftt_tap_delay.sv
// Shift register of (2**SEL_W - 1) stages with a runtime-selected tap.
// sel = 0 returns the current input, sel = k returns the value k accepted
// inputs ago.
module ftt_tap_delay #(
  parameter int DATA_W = 15,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] tap_o
);

  localparam int DEPTH = (1 << SEL_W) - 1;

  logic [DEPTH-1:0][DATA_W-1:0] taps;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    if (g == 0) begin : g_head
      always_comb d = en ? din : q;
    end else begin : g_body
      always_comb d = en ? g_stage[g-1].q : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign taps[g] = q;
  end

  always_comb begin
    tap_o = din;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel == SEL_W'(i + 1)) tap_o = taps[i];
    end
  end

endmodule

// File: rtl/ftt_shaper.sv
// Difference over D samples, then a running sum over L differences.
module ftt_shaper
  import fir_tot_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int LEN_W    = 6,
  localparam int DIFF_W  = ftt_diff_width(SAMPLE_W),
  localparam int SUM_W   = ftt_sum_width(SAMPLE_W, LEN_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [LEN_W-1:0]    diff_len,
  input  logic        [LEN_W-1:0]    int_len,
  output logic signed [SUM_W-1:0]    sum_next_o,
  output logic signed [SUM_W-1:0]    sum_o
);

  logic signed [SAMPLE_W-1:0] x_old;
  logic signed [DIFF_W-1:0]   diff;
  logic signed [DIFF_W-1:0]   d_old;
  logic signed [SUM_W-1:0]    sum_q;
  logic signed [SUM_W-1:0]    sum_d;

  ftt_tap_delay #(
    .DATA_W (SAMPLE_W),
    .SEL_W  (LEN_W)
  ) u_x_line (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .din   (sample),
    .sel   (diff_len),
    .tap_o (x_old)
  );

  assign diff = DIFF_W'(sample) - DIFF_W'(x_old);

  ftt_tap_delay #(
    .DATA_W (DIFF_W),
    .SEL_W  (LEN_W)
  ) u_d_line (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .din   (diff),
    .sel   (int_len),
    .tap_o (d_old)
  );

  // Incremental window: add the entering difference, drop the leaving one.
  assign sum_next_o = sum_q + SUM_W'(diff) - SUM_W'(d_old);

  always_comb begin
    sum_d = sum_q;
    if (en) sum_d = sum_next_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/ftt_tot_qual.sv
// Time-over-threshold qualifier: one pulse per above-threshold run.
module ftt_tot_qual #(
  parameter int SUM_W = 21,
  parameter int CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [SUM_W-1:0] level,
  input  logic signed [SUM_W-1:0] threshold,
  input  logic        [CNT_W-1:0] tot_count,
  output logic                    fire_o
);

  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic [CNT_W-1:0] run_q, run_d, run_inc, target;
  logic             fired_q, fired_d;
  logic             trig_q, trig_d;
  logic             above, fire;

  always_comb begin
    above   = level > threshold;
    run_inc = (run_q == RUN_MAX) ? run_q : run_q + CNT_W'(1);
    target  = (tot_count == '0) ? CNT_W'(1) : tot_count;
    fire    = en && above && !fired_q && (run_inc >= target);
  end

  always_comb begin
    run_d   = run_q;
    fired_d = fired_q;
    trig_d  = 1'b0;
    if (en) begin
      run_d   = above ? run_inc : '0;
      fired_d = above && (fired_q || fire);
      trig_d  = fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      fired_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      run_q   <= run_d;
      fired_q <= fired_d;
      trig_q  <= trig_d;
    end
  end

  assign fire_o = trig_q;

endmodule

// File: rtl/fir_tot_trigger.sv
module fir_tot_trigger
  import fir_tot_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int LEN_W    = 6,
  parameter int CNT_W    = 4,
  localparam int SUM_W   = ftt_sum_width(SAMPLE_W, LEN_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic        [LEN_W-1:0]    cfg_diff_len,
  input  logic        [LEN_W-1:0]    cfg_int_len,
  input  logic        [CNT_W-1:0]    cfg_tot_count,
  input  logic signed [SUM_W-1:0]    cfg_threshold,
  output logic signed [SUM_W-1:0]    shaped_o,
  output logic                       trig_o
);

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic signed [SUM_W-1:0] sum_next;

  // Assert asynchronously, release on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  ftt_shaper #(
    .SAMPLE_W (SAMPLE_W),
    .LEN_W    (LEN_W)
  ) u_shaper (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (in_valid),
    .sample     (in_sample),
    .diff_len   (cfg_diff_len),
    .int_len    (cfg_int_len),
    .sum_next_o (sum_next),
    .sum_o      (shaped_o)
  );

  ftt_tot_qual #(
    .SUM_W (SUM_W),
    .CNT_W (CNT_W)
  ) u_qual (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (in_valid),
    .level     (sum_next),
    .threshold (cfg_threshold),
    .tot_count (cfg_tot_count),
    .fire_o    (trig_o)
  );

endmodule

// File: rtl/fir_tot_trigger_chk.sv
module fir_tot_trigger_chk #(
  parameter int SUM_W = 21
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [SUM_W-1:0] cfg_threshold,
  input logic signed [SUM_W-1:0] shaped_o,
  input logic                    trig_o
);

  // R9
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R7
  trig_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(in_valid));

  // R6
  trig_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (shaped_o > cfg_threshold));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(shaped_o));

  // R3
  idle_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !trig_o);

endmodule

bind fir_tot_trigger fir_tot_trigger_chk #(
  .SUM_W (SUM_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .in_valid      (in_valid),
  .cfg_threshold (cfg_threshold),
  .shaped_o      (shaped_o),
  .trig_o        (trig_o)
);

// File: tb/fir_tot_trigger_tb.sv
module fir_tot_trigger_tb;

  localparam int SAMPLE_W = 14;
  localparam int LEN_W    = 6;
  localparam int CNT_W    = 4;
  localparam int SUM_W    = SAMPLE_W + 1 + LEN_W;
  localparam int NSAMP    = 140;

  logic                       clk;
  logic                       rst_n;
  logic                       in_valid;
  logic signed [SAMPLE_W-1:0] in_sample;
  logic        [LEN_W-1:0]    cfg_diff_len;
  logic        [LEN_W-1:0]    cfg_int_len;
  logic        [CNT_W-1:0]    cfg_tot_count;
  logic signed [SUM_W-1:0]    cfg_threshold;
  logic signed [SUM_W-1:0]    shaped_o;
  logic                       trig_o;

  int errors = 0;
  int checks = 0;

  fir_tot_trigger #(
    .SAMPLE_W (SAMPLE_W),
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sample     (in_sample),
    .cfg_diff_len  (cfg_diff_len),
    .cfg_int_len   (cfg_int_len),
    .cfg_tot_count (cfg_tot_count),
    .cfg_threshold (cfg_threshold),
    .shaped_o      (shaped_o),
    .trig_o        (trig_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int x_hist [0:NSAMP-1];
  int unsigned lcg = 32'h1234_5678;

  function automatic int xat(input int k);
    return (k < 0) ? 0 : x_hist[k];
  endfunction

  // Directly summed expected shaped value (R2).
  function automatic int ref_shaped(input int n, input int dl, input int il);
    int s = 0;
    for (int j = 0; j < il; j++) s += xat(n - j) - xat(n - j - dl);
    return s;
  endfunction

  task automatic run_config(input int dl, input int il, input int cnt, input int thr);
    int n = 0, run = 0, prev = 0;
    bit fired = 0;
    in_valid      = 1'b0;
    in_sample     = '0;
    cfg_diff_len  = LEN_W'(dl);
    cfg_int_len   = LEN_W'(il);
    cfg_tot_count = CNT_W'(cnt);
    cfg_threshold = SUM_W'(thr);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk(shaped_o == '0 && trig_o == 1'b0, "R1", int'(shaped_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: still cleared after release
    chk(shaped_o == '0 && trig_o == 1'b0, "R1", int'(shaped_o), 0);

    for (int k = 0; k < NSAMP; k++) begin
      int p = k % 40;
      int base, noise, smp, s;
      bit v = (k % 5) != 4;
      lcg   = lcg * 1103515245 + 12345;
      noise = int'((lcg >> 16) % 31) - 15;
      base  = (p < 10) ? 0 : (p < 20) ? 800 : (p < 24) ? 0 : (p < 26) ? 800 : -300;
      smp   = base + noise;
      in_valid  = v;
      in_sample = SAMPLE_W'(smp);
      @(posedge clk);
      #1;
      if (v) begin
        bit above, fire;
        int run_inc, target;
        string sreq, treq;
        x_hist[n] = smp;
        s = ref_shaped(n, dl, il);
        above   = s > thr;                       // R6: strictly greater
        run_inc = (run == 15) ? 15 : run + 1;
        target  = (cnt == 0) ? 1 : cnt;
        fire    = above && !fired && (run_inc >= target);
        run     = above ? run_inc : 0;
        fired   = above && (fired || fire);
        n++;
        sreq = (dl == 0) ? "R4" : (il == 0) ? "R5" : "R2";
        if (dl == 0 || il == 0)          treq = "R6";
        else if (fire && cnt <= 1)       treq = "R8";
        else if (fire)                   treq = "R7";
        else if (above && run_inc > target) treq = "R9";
        else                             treq = "R10";
        chk(int'(shaped_o) == s, sreq, int'(shaped_o), s);
        chk(trig_o == fire, treq, int'(trig_o), int'(fire));
        prev = s;
      end else begin
        // R3: idle edge holds the shaped value and raises no trigger
        chk(int'(shaped_o) == prev, "R3", int'(shaped_o), prev);
        chk(trig_o == 1'b0, "R3", int'(trig_o), 0);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    int dls [5] = '{0, 1, 2, 5, 63};
    int ils [5] = '{0, 1, 3, 7, 63};
    int cns [4] = '{0, 1, 3, 15};
    int thrs[4] = '{-40, 0, 150, 2000};
    rst_n         = 1'b1;
    in_valid      = 1'b0;
    in_sample     = '0;
    cfg_diff_len  = '0;
    cfg_int_len   = '0;
    cfg_tot_count = '0;
    cfg_threshold = '0;
    for (int di = 0; di < 5; di++) begin
      for (int li = 0; li < 5; li++) begin
        for (int ci = 0; ci < 4; ci++) begin
          run_config(dls[di], ils[li], cns[ci], thrs[(di + li + ci) % 4]);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule